// File: doc/BRIEF.md
# Audio Transmit FIFO Register Slave

This block is the software-facing front of an audio serial port. It decodes a 32-bit register bus with sixteen word-spaced registers. These hold the settings for the serial shifter and the clock generator: enable, format and clock divide values, plus the channel selection and channel mapping words. All of them come up at fixed reset values. Every write cycle is accepted at once. Every read cycle returns its data on the following cycle, flagged by a valid strobe.

A write-only data register feeds a small transmit FIFO. The serial shifter drains the FIFO through a valid/ready pair. Each word that leaves the FIFO advances a transmitted-sample counter, which software can load or clear.

Software, or a DMA engine, keeps the FIFO topped up. A DMA request is raised whenever the request is enabled and there is room for a full four-word burst. Setting a flush bit in the FIFO control register empties the FIFO straight away. The flush bits themselves never store a value.

Top module: `aud_fifo_regif`

## Requirements
- R1: After reset, registers read back these values:
  - format0 (offset 0x04): 0x0000000C
  - format1 (0x08): 0x00004020
  - FIFO control (0x14): 0x000400F0
  - TX channel select (0x30): 0x1
  - TX channel map (0x34): 0x76543210
  - RX channel select (0x38): 0x1
  - RX channel map (0x3C): 0x00003210
  - FIFO status (0x18): 0x00000800 (the FIFO is empty)
  - every other register: 0
- R2: The register index is address bits 5:2, so registers lie 4 bytes apart. Control (0x00), both format words, DMA control (0x1C), clock divide (0x24) and the four channel words store all 32 written bits and read them back.
- R3: The TX data port (0x0C) reads 0. Writes to RX data (0x10), FIFO status (0x18), interrupt status (0x20) and RX count (0x28) are ignored. RX data, interrupt status and RX count read 0.
- R4: FIFO control bits 25 and 24 read back as 0, and all its other bits are stored. A write with bit 25 set leaves the FIFO empty one cycle later, with `tx_valid` low and a fill level of 0.
- R5: Words written to 0x0C appear on `tx_data` in write order. `tx_valid` is high while the FIFO holds data, and a word is consumed on a cycle where both `tx_valid` and `tx_ready` are high.
- R6: A write to 0x0C while the FIFO holds DEPTH words is dropped, and the fill level never exceeds DEPTH.
- R7: The TX count register (0x2C) increments by one per consumed word. A write loads the written value, so writing 0 clears it. A write on the same cycle as a consume wins.
- R8: `tx_dma_req` is high exactly when DMA control bit 7 is set and at least BURST (4) FIFO entries are free. DMA control bit 3 is stored but drives nothing.
- R9: FIFO status (0x18) reports the fill level in bits 7:0 and the number of free entries in bits 15:8. All other bits read 0.
- R10: A read request returns its data on `bus_rdata` with `bus_rvalid` high in the following cycle. `cfg_ctrl`, `cfg_fmt0` and `cfg_clkdiv` always show the control, format0 and clock divide registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address; bits 5:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| tx_valid | output | 1 | FIFO head word available |
| tx_ready | input | 1 | Shifter accepts the head word |
| tx_data | output | 32 | FIFO head word |
| tx_dma_req | output | 1 | Room for a DMA burst and request enabled |
| cfg_ctrl | output | 32 | Control register contents |
| cfg_fmt0 | output | 32 | Format0 register contents |
| cfg_clkdiv | output | 32 | Clock divide register contents |

## Verification
The hardest case to reach is a load of the TX count register that falls on the same clock edge as a consume by the shifter. The bench first parks two words in the FIFO with `tx_ready` low. It then raises `tx_ready` on the very cycle it writes the count register. The final count tells the two precedence orders apart. The full-FIFO drop and the DMA threshold are reached by filling the FIFO with the shifter stalled. The level is read through the status register and checked after each step.

// File: rtl/aud_fifo_regif_pkg.sv
package aud_fifo_regif_pkg;

  localparam int unsigned NUM_REGS = 16;
  localparam int unsigned IDX_W    = 4;

  typedef enum logic [IDX_W-1:0] {
    IDX_CTRL    = 4'd0,
    IDX_FMT0    = 4'd1,
    IDX_FMT1    = 4'd2,
    IDX_TXDATA  = 4'd3,
    IDX_RXDATA  = 4'd4,
    IDX_FIFOCTL = 4'd5,
    IDX_FIFOSTA = 4'd6,
    IDX_DMACTL  = 4'd7,
    IDX_INTSTA  = 4'd8,
    IDX_CLKDIV  = 4'd9,
    IDX_RXCNT   = 4'd10,
    IDX_TXCNT   = 4'd11,
    IDX_TXCHSEL = 4'd12,
    IDX_TXCHMAP = 4'd13,
    IDX_RXCHSEL = 4'd14,
    IDX_RXCHMAP = 4'd15
  } reg_idx_e;

  localparam int unsigned FLUSH_TX_BIT  = 25;
  localparam int unsigned FLUSH_RX_BIT  = 24;
  localparam int unsigned DMA_TX_EN_BIT = 7;

  function automatic logic [31:0] reg_reset(input int unsigned idx);
    case (idx)
      IDX_FMT0:    return 32'h0000_000C;
      IDX_FMT1:    return 32'h0000_4020;
      IDX_FIFOCTL: return 32'h0004_00F0;
      IDX_TXCHSEL: return 32'h0000_0001;
      IDX_TXCHMAP: return 32'h7654_3210;
      IDX_RXCHSEL: return 32'h0000_0001;
      IDX_RXCHMAP: return 32'h0000_3210;
      default:     return 32'h0000_0000;
    endcase
  endfunction

  // Bits that a write stores; zero means the slot holds no storage.
  function automatic logic [31:0] reg_wmask(input int unsigned idx);
    case (idx)
      IDX_CTRL, IDX_FMT0, IDX_FMT1, IDX_DMACTL, IDX_CLKDIV,
      IDX_TXCHSEL, IDX_TXCHMAP, IDX_RXCHSEL, IDX_RXCHMAP:
        return 32'hFFFF_FFFF;
      IDX_FIFOCTL:
        return ~((32'h1 << FLUSH_TX_BIT) | (32'h1 << FLUSH_RX_BIT));
      default:
        return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/aud_tx_fifo.sv
module aud_tx_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             flush,
  input  logic             pop_ready,
  output logic             head_valid,
  output logic [WIDTH-1:0] head_data,
  output logic [LVL_W-1:0] level,
  output logic [LVL_W-1:0] free
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [LVL_W-1:0] level_q, level_d;
  logic             push_ok, pop_ok, ptr_en;

  assign push_ok = push && (level_q != LVL_W'(DEPTH));
  assign pop_ok  = pop_ready && (level_q != '0);
  assign ptr_en  = flush || push_ok || pop_ok;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    level_d  = level_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      level_d  = '0;
    end else begin
      if (push_ok) wr_ptr_d = bump(wr_ptr_q);
      if (pop_ok)  rd_ptr_d = bump(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   level_d = level_q + 1'b1;
        2'b01:   level_d = level_q - 1'b1;
        default: level_d = level_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else if (ptr_en) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr_q] <= push_data;
  end

  assign head_valid = (level_q != '0);
  assign head_data  = mem[rd_ptr_q];
  assign level      = level_q;
  assign free       = LVL_W'(DEPTH) - level_q;

endmodule

// File: rtl/aud_regbank.sv
module aud_regbank
  import aud_fifo_regif_pkg::*;
#(
  parameter int unsigned LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [LVL_W-1:0] fifo_free,
  input  logic             tx_pop,
  output logic [31:0]      rdata,
  output logic             rvalid,
  output logic [31:0]      ctrl_o,
  output logic [31:0]      fmt0_o,
  output logic [31:0]      clkdiv_o,
  output logic             dma_tx_en,
  output logic [31:0]      tx_cnt
);

  logic [31:0] store_w [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [31:0] MASK = reg_wmask(i);
    localparam logic [31:0] RSTV = reg_reset(i);
    if (MASK != 32'h0) begin : g_store
      logic [31:0] q, d;
      logic        we;
      assign we = wr_en && (idx == IDX_W'(i));
      assign d  = wdata & MASK;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= RSTV;
        else if (we) q <= d;
      end
      assign store_w[i] = q;
    end else begin : g_none
      assign store_w[i] = 32'h0;
    end
  end

  // transmitted-sample counter: a bus write takes precedence over a consume
  logic [31:0] cnt_q, cnt_d;
  logic        cnt_wr, cnt_en;
  assign cnt_wr = wr_en && (idx == IDX_TXCNT);
  assign cnt_en = cnt_wr || tx_pop;

  always_comb begin
    if (cnt_wr) cnt_d = wdata;
    else        cnt_d = cnt_q + 32'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  logic [31:0] rd_mux, rdata_q;
  logic        rvalid_q;

  always_comb begin
    case (idx)
      IDX_TXCNT:   rd_mux = cnt_q;
      IDX_FIFOSTA: rd_mux = {16'h0, 8'(fifo_free), 8'(fifo_level)};
      default:     rd_mux = store_w[idx];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  assign rdata     = rdata_q;
  assign rvalid    = rvalid_q;
  assign ctrl_o    = store_w[IDX_CTRL];
  assign fmt0_o    = store_w[IDX_FMT0];
  assign clkdiv_o  = store_w[IDX_CLKDIV];
  assign dma_tx_en = store_w[IDX_DMACTL][DMA_TX_EN_BIT];
  assign tx_cnt    = cnt_q;

endmodule

// File: rtl/aud_fifo_regif.sv
module aud_fifo_regif
  import aud_fifo_regif_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned BURST = 4,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [31:0] tx_data,
  output logic        tx_dma_req,
  output logic [31:0] cfg_ctrl,
  output logic [31:0] cfg_fmt0,
  output logic [31:0] cfg_clkdiv
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [IDX_W-1:0] reg_idx;
  logic             wr_en, rd_en, push, flush_tx, pop;
  logic [LVL_W-1:0] level, free;
  logic             dma_tx_en;
  logic [31:0]      tx_cnt;
  logic             unused_addr;

  assign reg_idx     = bus_addr[5:2];
  assign unused_addr = ^bus_addr[1:0];
  assign wr_en       = bus_sel && bus_wr;
  assign rd_en       = bus_sel && !bus_wr;
  assign push        = wr_en && (reg_idx == IDX_TXDATA);
  assign flush_tx    = wr_en && (reg_idx == IDX_FIFOCTL) && bus_wdata[FLUSH_TX_BIT];
  assign pop         = tx_valid && tx_ready;

  aud_tx_fifo #(.WIDTH(32), .DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .push       (push),
    .push_data  (bus_wdata),
    .flush      (flush_tx),
    .pop_ready  (tx_ready),
    .head_valid (tx_valid),
    .head_data  (tx_data),
    .level      (level),
    .free       (free)
  );

  aud_regbank #(.LVL_W(LVL_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .idx        (reg_idx),
    .wdata      (bus_wdata),
    .fifo_level (level),
    .fifo_free  (free),
    .tx_pop     (pop),
    .rdata      (bus_rdata),
    .rvalid     (bus_rvalid),
    .ctrl_o     (cfg_ctrl),
    .fmt0_o     (cfg_fmt0),
    .clkdiv_o   (cfg_clkdiv),
    .dma_tx_en  (dma_tx_en),
    .tx_cnt     (tx_cnt)
  );

  assign tx_dma_req = dma_tx_en && (free >= LVL_W'(BURST));

endmodule

// File: rtl/aud_fifo_regif_chk.sv
module aud_fifo_regif_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned BURST = 4,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [3:0]       bus_idx,
  input logic [31:0]      bus_wdata,
  input logic             bus_rvalid,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             tx_dma_req,
  input logic [LVL_W-1:0] level,
  input logic [31:0]      tx_cnt
);

  assert_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_sel && !bus_wr) |=> bus_rvalid);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    level <= LVL_W'(DEPTH));

  assert_flush_empties_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_sel && bus_wr && bus_idx == 4'd5 && bus_wdata[25]) |=> (level == '0 && !tx_valid));

  assert_dma_room_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    tx_dma_req |-> (level <= LVL_W'(DEPTH - BURST)));

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    (tx_valid && tx_ready && !(bus_sel && bus_wr && bus_idx == 4'd11))
      |=> (tx_cnt == $past(tx_cnt) + 32'd1));

  assert_count_load_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_sel && bus_wr && bus_idx == 4'd11) |=> (tx_cnt == $past(bus_wdata)));

endmodule

bind aud_fifo_regif aud_fifo_regif_chk #(.DEPTH(DEPTH), .BURST(BURST)) u_chk (
  .clk        (clk),
  .rst_ok     (rst_sync_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_idx    (reg_idx),
  .bus_wdata  (bus_wdata),
  .bus_rvalid (bus_rvalid),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_dma_req (tx_dma_req),
  .level      (level),
  .tx_cnt     (tx_cnt)
);

// File: tb/aud_fifo_regif_bench.sv
module aud_fifo_regif_bench;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, tx_ready = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, tx_data, cfg_ctrl, cfg_fmt0, cfg_clkdiv;
  logic        bus_rvalid, tx_valid, tx_dma_req;

  always #4 clk = ~clk;

  aud_fifo_regif u_aud_fifo_regif (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_dma_req(tx_dma_req), .cfg_ctrl(cfg_ctrl),
    .cfg_fmt0(cfg_fmt0), .cfg_clkdiv(cfg_clkdiv)
  );

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_q [$];
  bit done = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    check("R10 rvalid", {31'b0, bus_rvalid}, 32'd1);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic read_check(input string req, input logic [5:0] a, input logic [31:0] e);
    logic [31:0] d;
    bus_read(a, d);
    check(req, d, e);
  endtask

  // driver: data-port write with predicted acceptance
  task automatic push_word(input logic [31:0] d);
    if (exp_q.size() < DEPTH) exp_q.push_back(d);
    bus_write(6'h0C, d);
  endtask

  // monitor: scoreboard compare of each consumed word
  always begin
    @(negedge clk);
    #2;
    if (tx_valid === 1'b1 && tx_ready === 1'b1) begin
      if (exp_q.size() == 0) check("R5 unexpected word", tx_data, 32'hxxxx_xxxx);
      else check("R5 order", tx_data, exp_q.pop_front());
    end
  end

  function automatic logic [31:0] rst_val(input int i);
    case (i)
      1: return 32'h0000_000C;
      2: return 32'h0000_4020;
      5: return 32'h0004_00F0;
      6: return 32'h0000_0800;
      12: return 32'h1;
      13: return 32'h7654_3210;
      14: return 32'h1;
      15: return 32'h0000_3210;
      default: return 32'h0;
    endcase
  endfunction

  task automatic drain();
    tx_ready = 1'b1;
    while (tx_valid === 1'b1) @(negedge clk);
    tx_ready = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset values
    for (int i = 0; i < 16; i++) read_check("R1 reset value", 6'(i * 4), rst_val(i));
    check("R5 idle valid", {31'b0, tx_valid}, 32'd0);
    check("R8 dma off", {31'b0, tx_dma_req}, 32'd0);

    // R2: storable registers
    bus_write(6'h00, 32'hA5A5_0F0F); read_check("R2 ctrl", 6'h00, 32'hA5A5_0F0F);
    bus_write(6'h04, 32'h1234_5678); read_check("R2 fmt0", 6'h04, 32'h1234_5678);
    bus_write(6'h08, 32'hDEAD_BEEF); read_check("R2 fmt1", 6'h08, 32'hDEAD_BEEF);
    bus_write(6'h24, 32'h0000_00B3); read_check("R2 clkdiv", 6'h24, 32'h0000_00B3);
    bus_write(6'h30, 32'h0000_0003); read_check("R2 txchsel", 6'h30, 32'h0000_0003);
    bus_write(6'h34, 32'h0123_4567); read_check("R2 txchmap", 6'h34, 32'h0123_4567);
    bus_write(6'h38, 32'hFFFF_FFFF); read_check("R2 rxchsel", 6'h38, 32'hFFFF_FFFF);
    bus_write(6'h3C, 32'h5555_AAAA); read_check("R2 rxchmap", 6'h3C, 32'h5555_AAAA);
    bus_write(6'h1C, 32'h0000_0008); read_check("R2 dmactl", 6'h1C, 32'h0000_0008);
    check("R8 rx enable only", {31'b0, tx_dma_req}, 32'd0);

    // R10: configuration outputs
    check("R10 cfg_ctrl", cfg_ctrl, 32'hA5A5_0F0F);
    check("R10 cfg_fmt0", cfg_fmt0, 32'h1234_5678);
    check("R10 cfg_clkdiv", cfg_clkdiv, 32'h0000_00B3);

    // R4: flush bits do not store
    bus_write(6'h14, 32'h0300_0007); read_check("R4 fifoctl", 6'h14, 32'h0000_0007);

    // R3: read-only and write-only
    bus_write(6'h10, 32'hFFFF_FFFF); read_check("R3 rxdata", 6'h10, 32'h0);
    bus_write(6'h20, 32'hFFFF_FFFF); read_check("R3 intsta", 6'h20, 32'h0);
    bus_write(6'h28, 32'hFFFF_FFFF); read_check("R3 rxcnt", 6'h28, 32'h0);
    bus_write(6'h18, 32'hFFFF_FFFF); read_check("R3 fifosta", 6'h18, 32'h0000_0800);
    push_word(32'h1111_0001);
    read_check("R3 txdata reads 0", 6'h0C, 32'h0);
    read_check("R9 one word", 6'h18, 32'h0000_0701);

    // R4: flush empties
    push_word(32'h1111_0002);
    push_word(32'h1111_0003);
    bus_write(6'h14, 32'h0200_0007);
    exp_q.delete();
    check("R4 valid after flush", {31'b0, tx_valid}, 32'd0);
    read_check("R4 level after flush", 6'h18, 32'h0000_0800);

    // R8: DMA threshold
    bus_write(6'h1C, 32'h0000_0080);
    check("R8 empty", {31'b0, tx_dma_req}, 32'd1);
    for (int i = 0; i < 4; i++) push_word(32'h2000_0000 + 32'(i));
    check("R8 four free", {31'b0, tx_dma_req}, 32'd1);
    push_word(32'h2000_0004);
    check("R8 three free", {31'b0, tx_dma_req}, 32'd0);

    // R6: fill and overflow
    for (int i = 5; i < 8; i++) push_word(32'h2000_0000 + 32'(i));
    read_check("R9 full", 6'h18, 32'h0000_0008);
    push_word(32'hBAD0_BAD0);
    read_check("R6 drop when full", 6'h18, 32'h0000_0008);

    // R7 / R5: clear counter, drain through scoreboard
    bus_write(6'h2C, 32'h0);
    read_check("R7 cleared", 6'h2C, 32'h0);
    drain();
    check("R5 queue drained", 32'(exp_q.size()), 32'd0);
    read_check("R7 eight consumed", 6'h2C, 32'd8);
    check("R8 empty again", {31'b0, tx_dma_req}, 32'd1);

    // R7: load collides with consume
    push_word(32'h3000_0000);
    push_word(32'h3000_0001);
    tx_ready = 1'b1;
    bus_write(6'h2C, 32'd5);
    while (tx_valid === 1'b1) @(negedge clk);
    tx_ready = 1'b0;
    read_check("R7 write wins over consume", 6'h2C, 32'd6);
    check("R5 queue drained again", 32'(exp_q.size()), 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule